// File: doc/BRIEF.md
# Glitch-Free Clock Steering Switch

This block takes one free-running clock and sends it to one of two output clock lines. A single select input decides which line carries the clock. The select may change at any moment and has no timing relation to the clock. Even so, each output only ever shows complete high pulses of the input clock. A pulse is never cut short and never starts late.

The select is first brought into the clock domain by a short chain of flops clocked on the falling edge. A small break-before-make sequencer then decides which output is enabled. The output being dropped is switched off first. One full clock cycle later, the new output is switched on. Each output has its own gating cell, and its enable can only change while the input clock is low. This makes each gating cell equivalent to a low-transparent latch followed by an AND.

A typical use is to steer a shared clock between two consumers that may not both run at once. The select level encodes the destination: low selects output A, high selects output B.

Top module: `clkSteerSwitch`

## Requirements
- R1: While `rstN` is low, both `clkOutA` and `clkOutB` stay low, whatever `selAsync` does.
- R2: With `selAsync` held low long enough to settle, `clkOutA` follows `clkIn` and `clkOutB` stays low.
- R3: With `selAsync` held high long enough to settle, `clkOutB` follows `clkIn` and `clkOutA` stays low.
- R4: Every high pulse on either output starts at a rising edge of `clkIn` and lasts exactly one high phase of `clkIn`. No truncated or runt pulse occurs, including during handovers, resets and select bursts.
- R5: The two outputs are never high at the same time. At every handover, at least one full `clkIn` high phase passes with neither output pulsing.
- R6: After `rstN` rises with `selAsync` steady, the high phases ending at falling edges 2, 3 and 4 after the release show no output pulse. Falling edge 1 is the first falling edge after the release. The high phase ending at falling edge 5 pulses on the selected output.
- R7: Edge 1 is the first falling edge of `clkIn` that sees a new select level. After a select change, the old output still pulses in the high phases ending at edges 2, 3 and 4. Neither output pulses in the high phase ending at edge 5. The new output pulses from the high phase ending at edge 6 onward.
- R8: A select excursion that starts and ends within one interval between two falling edges of `clkIn` has no effect. The active output keeps pulsing every cycle.
- R9: After any burst of select changes, including excursions captured by a single falling edge, the switch settles on the final select level within 10 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Free-running input clock to be steered |
| rstN | input | 1 | Active-low asynchronous reset |
| selAsync | input | 1 | Destination select, asynchronous; 0 = output A, 1 = output B |
| clkOutA | output | 1 | Gated copy of `clkIn` for destination A |
| clkOutB | output | 1 | Gated copy of `clkIn` for destination B |

## Verification
Handovers are swept in both directions over every nanosecond offset of the select change within the 20 ns clock period, except the exact falling-edge instant. This shows that the handover timing depends only on which falling edge first captures the change, and not on where in the high or low phase the change lands. Reset release is tried in both the high and the low phase with each select level, which pins down the startup latency separately from the handover latency. Short select blips inside one phase, one-edge bounces and a fast toggle burst separate an ignored glitch from a captured one that must still resolve cleanly. A pulse-width monitor and a same-cycle monitor watch the outputs throughout every pattern.

// File: rtl/clkSteerPkg.sv
`timescale 1ns/1ps
package clkSteerPkg;

  typedef enum logic [1:0] {
    ST_OFF = 2'd0,
    ST_A   = 2'd1,
    ST_B   = 2'd2
  } steerState_e;

  // gate enable strobes from control to the gating datapath
  typedef struct packed {
    logic enB;
    logic enA;
  } gateStrb_t;

endpackage

// File: rtl/clkSteerCtrl.sv
`timescale 1ns/1ps
module clkSteerCtrl
  import clkSteerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clkIn,
  input  logic      rstN,
  input  logic      selAsync,
  output gateStrb_t strb
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] syncQ;
  logic [MSB:0] vldQ;
  logic         want;
  logic         syncVld;
  steerState_e  state, stateNext;

  // select synchronizer and fill tracker, both on the falling edge
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      vldQ  <= '0;
    end else begin
      syncQ <= {syncQ[MSB-1:0], selAsync};
      vldQ  <= {vldQ[MSB-1:0], 1'b1};
    end
  end

  assign want    = syncQ[MSB];
  assign syncVld = vldQ[MSB];

  // break-before-make sequencer
  always_comb begin
    stateNext = state;
    unique case (state)
      ST_OFF:  if (syncVld) stateNext = want ? ST_B : ST_A;
      ST_A:    if (want)    stateNext = ST_OFF;
      ST_B:    if (!want)   stateNext = ST_OFF;
      default:              stateNext = ST_OFF;
    endcase
  end

  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign strb.enA = (state == ST_A);
  assign strb.enB = (state == ST_B);

  // R6
  no_early_enable_chk: assert property (@(negedge clkIn) disable iff (!rstN)
    (state != ST_OFF) |-> syncVld);

  // R7
  release_a_first_chk: assert property (@(negedge clkIn) disable iff (!rstN)
    (state == ST_A && want) |=> (state == ST_OFF));

  // R7
  release_b_first_chk: assert property (@(negedge clkIn) disable iff (!rstN)
    (state == ST_B && !want) |=> (state == ST_OFF));

  // R5
  no_direct_swap_chk: assert property (@(negedge clkIn) disable iff (!rstN)
    (state == ST_A) |=> (state != ST_B));

endmodule

// File: rtl/clkSteerGate.sv
`timescale 1ns/1ps
module clkSteerGate
  import clkSteerPkg::*;
#(
  parameter int NUM_OUT = 2
) (
  input  logic               clkIn,
  input  logic               rstN,
  input  gateStrb_t          strb,
  output logic [NUM_OUT-1:0] clkOut
);

  logic [NUM_OUT-1:0] enVec;
  logic [NUM_OUT-1:0] gateQ;

  assign enVec = {strb.enB, strb.enA};

  // enable capture only while clkIn is low: behaves as a low-transparent latch
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) gateQ <= '0;
    else       gateQ <= enVec;
  end

  for (genvar g = 0; g < NUM_OUT; g++) begin : gCell
    assign clkOut[g] = clkIn & gateQ[g];
  end

  // R5
  exclusive_gate_chk: assert property (@(negedge clkIn) disable iff (!rstN)
    $onehot0(gateQ));

  // R5
  gap_on_handover_chk: assert property (@(negedge clkIn) disable iff (!rstN)
    ($past(gateQ) != '0 && gateQ != '0) |-> (gateQ == $past(gateQ)));

endmodule

// File: rtl/clkSteerSwitch.sv
`timescale 1ns/1ps
module clkSteerSwitch
  import clkSteerPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkIn,
  input  logic rstN,
  input  logic selAsync,
  output logic clkOutA,
  output logic clkOutB
);

  gateStrb_t  strb;
  logic [1:0] clkOutVec;

  clkSteerCtrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .selAsync (selAsync),
    .strb     (strb)
  );

  clkSteerGate #(.NUM_OUT(2)) uGate (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .strb   (strb),
    .clkOut (clkOutVec)
  );

  assign clkOutA = clkOutVec[0];
  assign clkOutB = clkOutVec[1];

endmodule

// File: tb/tb_clkSteerSwitch.sv
`timescale 1ns/1ps
module tb_clkSteerSwitch;

  logic clkIn = 1'b0;
  logic rstN  = 1'b0;
  logic sel   = 1'b0;
  logic outA, outB;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  always #10 clkIn = ~clkIn;

  clkSteerSwitch dut (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .selAsync (sel),
    .clkOutA  (outA),
    .clkOutB  (outB)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // R4: pulse width monitors (high phase is 10 ns = 10000 ps)
  realtime riseA, riseB;
  bit seenA = 1'b0, seenB = 1'b0;
  always @(posedge outA) begin riseA = $realtime; seenA = 1'b1; end
  always @(posedge outB) begin riseB = $realtime; seenB = 1'b1; end
  always @(negedge outA) if (seenA) begin
    chk(int'(($realtime - riseA) * 1000.0) == 10000, "R4", "clkOutA pulse width ps",
        int'(($realtime - riseA) * 1000.0), 10000);
    seenA = 1'b0;
  end
  always @(negedge outB) if (seenB) begin
    chk(int'(($realtime - riseB) * 1000.0) == 10000, "R4", "clkOutB pulse width ps",
        int'(($realtime - riseB) * 1000.0), 10000);
    seenB = 1'b0;
  end

  // R5: never both pulsing in one cycle
  always @(posedge clkIn) begin
    #5;
    if (rstN) chk(!(outA && outB), "R5", "both outputs high", {outA, outB}, 0);
  end

  // sample in the middle of the next high phase
  task automatic midHigh(output logic a, output logic b);
    @(posedge clkIn);
    #5;
    a = outA;
    b = outB;
  endtask

  task automatic steady(input logic s, input int n, input string req);
    logic a, b;
    for (int i = 0; i < n; i++) begin
      midHigh(a, b);
      chk(a == !s && b == s, req, "steady high-phase {A,B}", {a, b}, {!s, s});
      #10;
      chk(outA == 1'b0 && outB == 1'b0, req, "steady low-phase {A,B}", {outA, outB}, 0);
    end
  endtask

  task automatic resetRun(input int relPhase, input logic s);
    logic a, b;
    @(posedge clkIn); #13; rstN = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clkIn); #3; sel = ~sel; #2;
      chk(outA == 1'b0 && outB == 1'b0, "R1", "outputs in reset", {outA, outB}, 0);
      #10;
      chk(outA == 1'b0 && outB == 1'b0, "R1", "outputs in reset low phase", {outA, outB}, 0);
    end
    sel = s;
    @(posedge clkIn); #relPhase; rstN = 1'b1;
    @(negedge clkIn); // edge 1
    for (int j = 2; j <= 5; j++) begin
      midHigh(a, b);
      if (j < 5) chk(a == 1'b0 && b == 1'b0, "R6", $sformatf("early pulse edge %0d", j), {a, b}, 0);
      else       chk(a == !s && b == s, "R6", "first pulse {A,B}", {a, b}, {!s, s});
    end
    steady(s, 6, s ? "R3" : "R2");
  endtask

  task automatic handover(input int phase);
    logic a, b, oldS, newS, oldOut, newOut;
    oldS = sel;
    newS = ~sel;
    @(posedge clkIn); #phase; sel = newS;
    @(negedge clkIn); // edge 1
    for (int j = 2; j <= 7; j++) begin
      midHigh(a, b);
      oldOut = oldS ? b : a;
      newOut = newS ? b : a;
      if (j <= 4) chk(oldOut && !newOut, "R7", $sformatf("ph%0d edge%0d old active", phase, j), {oldOut, newOut}, 2);
      else if (j == 5) chk(!oldOut && !newOut, "R5", $sformatf("ph%0d idle gap", phase), {oldOut, newOut}, 0);
      else chk(!oldOut && newOut, "R7", $sformatf("ph%0d edge%0d new active", phase, j), {oldOut, newOut}, 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clkIn);
    if (!done) begin
      errors++;
      $display("FAIL watchdog all-requirements actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    // R1, R6, R2, R3: reset release in high and low phase, both selections
    resetRun(3, 1'b0);
    resetRun(13, 1'b1);
    resetRun(13, 1'b0);
    resetRun(3, 1'b1);

    // R7, R5, R4: handover sweep across every offset in the period, both directions
    for (int p = 0; p < 20; p++) begin
      if (p == 10) continue;
      handover(p);
      handover(p);
    end
    steady(sel, 3, sel ? "R3" : "R2");

    // R8: blips within one phase are never captured
    for (int k = 0; k < 4; k++) begin
      @(posedge clkIn); #2; sel = ~sel; #5; sel = ~sel;
      @(negedge clkIn); #4; sel = ~sel; #8; sel = ~sel;
    end
    steady(sel, 6, "R8");

    // R9: captured one-edge bounce resolves back
    @(posedge clkIn); #3; sel = ~sel;
    @(posedge clkIn); #3; sel = ~sel;
    repeat (10) @(posedge clkIn);
    steady(sel, 4, "R9");

    // R9: fast toggle burst, then settle on final level
    for (int k = 0; k < 17; k++) begin
      #7; sel = ~sel;
    end
    repeat (10) @(posedge clkIn);
    steady(sel, 4, "R9");
    for (int k = 0; k < 12; k++) begin
      #13; sel = ~sel;
    end
    #5; sel = ~sel;
    repeat (10) @(posedge clkIn);
    steady(sel, 4, "R9");

    done = 1'b1;
    finishRun();
  end

endmodule